// File: doc/BRIEF.md
# Receive Character Holding Buffer

This block sits between a serial receiver's deserializer and a host register interface. Each time the deserializer finishes a character of 5, 6, 7, 8 or 9 bits, it raises a one-cycle valid strobe. With that strobe it presents the raw character and that character's frame-error and parity-error flags. The block trims the character to the configured size and stores it with its flags in a small first-in first-out store. It also detects overrun locally: a character that arrives while the store is full is lost, and the loss is marked on the newest stored character.

The host reads three locations: a status byte, a high-bit byte that carries the ninth data bit, and a data byte. Each error flag and the ninth bit belong to one stored entry and move through the store with it. Any status or high-bit read therefore describes the character at the head of the store. Only a read of the data byte removes that character. A host that uses 9-bit characters reads status and the high bit first, then the data byte. Dropping the receiver enable empties the store.

Top module: `rx_hold_fifo`

## Requirements
- R1: After reset the status byte reads 0x00, the high-bit byte reads 0x00 and the data byte reads 0x00.
- R2: Status bit 7 (ready) is 1 exactly when at least one unread character is stored, and it returns to 0 once the last one is removed.
- R3: Characters leave in arrival order. The store holds DEPTH (default 2) entries, and a data read (address 2 with the read strobe) removes the head entry at the clock edge.
- R4: The size code selects the character width: 0, 1, 2 and 3 give 5, 6, 7 and 8 bits, 7 gives 9 bits, and 4 to 6 act as 8 bits. Bits above the configured width read as zero in the data byte.
- R5: With size code 7, bit 0 of the high-bit byte (address 1) shows data bit 8 of the head character. With any other code that bit reads 0. All other bits of the byte read 0.
- R6: The status byte shows the head entry's flags: bit 2 frame error, bit 1 overrun, bit 0 parity error. After a removal these bits show the next entry, and they read 0 when the store is empty.
- R7: A valid strobe that arrives while the store is full and no removal happens in that cycle discards the incoming character and sets the overrun flag of the newest stored entry.
- R8: Reads of the status byte (address 0) and the high-bit byte (address 1) never remove an entry.
- R9: A data read on an empty store returns the byte most recently removed, or 0x00 if none has been removed since reset, and leaves the store unchanged.
- R10: A valid strobe and a data read in the same cycle are both honoured, also when the store is full, and no overrun is set in that case.
- R11: While the receive enable is low, the store is emptied at every clock, status bit 7 reads 0 and valid strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxEnable | input | 1 | Receiver enable; low flushes the store |
| charSize | input | 3 | Character size code |
| inValid | input | 1 | One-cycle strobe for a completed character |
| inData | input | 9 | Raw received character, LSB in bit 0 |
| inFrameErr | input | 1 | Frame error of the incoming character |
| inParityErr | input | 1 | Parity error of the incoming character |
| rdEn | input | 1 | Host read strobe |
| rdAddr | input | 2 | Read location: 0 status, 1 high bit, 2 data, 3 reads zero |
| rdValue | output | 8 | Read data for the addressed location, combinational |

## Verification
The main path is driven in several ways. Single characters are read back one at a time. Two characters are stacked and then drained. Characters arrive in a burst that overfills the store. Pushes and removals land on the same edge. Data patterns are spread over all size codes with the upper bits set, which shows whether masking is applied per width and whether the ninth bit reaches only the high-bit byte in 9-bit mode. The error flags are given different values in adjacent characters, so a global sticky flag is told apart from per-entry flags. Empty-store reads, reads of the non-removing addresses, and flushes with strobes pending show whether removal and intake are gated correctly.

// File: rtl/rx_hold_pkg.sv
package rx_hold_pkg;

  typedef enum logic [1:0] {
    ADDR_STAT = 2'd0,
    ADDR_HIGH = 2'd1,
    ADDR_DATA = 2'd2,
    ADDR_NONE = 2'd3
  } rdAddr_e;

  localparam int STAT_READY  = 7;
  localparam int STAT_FRAME  = 2;
  localparam int STAT_OVRUN  = 1;
  localparam int STAT_PARITY = 0;

  localparam logic [2:0] SIZE_NINE = 3'b111;

  typedef struct packed {
    logic [8:0] data;
    logic       frameErr;
    logic       overrun;
    logic       parityErr;
  } rxEntry_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
    logic markOvr;
  } fifoStrb_t;

  function automatic logic [8:0] maskChar(input logic [8:0] raw, input logic [2:0] size);
    logic [8:0] keep;
    case (size)
      3'd0:      keep = 9'h01F;
      3'd1:      keep = 9'h03F;
      3'd2:      keep = 9'h07F;
      SIZE_NINE: keep = 9'h1FF;
      default:   keep = 9'h0FF;
    endcase
    return raw & keep;
  endfunction

endpackage

// File: rtl/rx_hold_ctrl.sv
module rx_hold_ctrl
  import rx_hold_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxEnable,
  input  logic             inValid,
  input  logic             rdEn,
  input  logic [1:0]       rdAddr,
  output fifoStrb_t        strb,
  output logic [CNT_W-1:0] fillCount
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic isFull;
  logic isEmpty;
  logic dataRead;

  assign isFull   = (fillCount == FULL_CNT);
  assign isEmpty  = (fillCount == '0);
  assign dataRead = rdEn && (rdAddr == ADDR_DATA);

  always_comb begin
    strb         = '0;
    strb.flush   = !rxEnable;
    strb.pop     = rxEnable && dataRead && !isEmpty;
    strb.push    = rxEnable && inValid && (!isFull || strb.pop);
    strb.markOvr = rxEnable && inValid && isFull && !strb.pop;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCount <= '0;
    end else if (strb.flush) begin
      fillCount <= '0;
    end else begin
      case ({strb.push, strb.pop})
        2'b10:   fillCount <= fillCount + 1'b1;
        2'b01:   fillCount <= fillCount - 1'b1;
        default: fillCount <= fillCount;
      endcase
    end
  end

endmodule

// File: rtl/rx_hold_dpath.sv
module rx_hold_dpath
  import rx_hold_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rstN,
  input  fifoStrb_t  strb,
  input  logic [2:0] charSize,
  input  logic [8:0] inData,
  input  logic       inFrameErr,
  input  logic       inParityErr,
  input  logic [1:0] rdAddr,
  output logic [7:0] rdValue
);

  rxEntry_t [DEPTH-1:0] slots;
  logic [PW:0]   wrPtr;
  logic [PW:0]   rdPtr;
  logic [PW:0]   wrPrev;
  logic [PW-1:0] wrIdx;
  logic [PW-1:0] rdIdx;
  logic [PW-1:0] newestIdx;
  logic [7:0]    lastData;
  logic          bufEmpty;
  rxEntry_t      headEntry;
  rxEntry_t      newEntry;
  logic          ninthBit;

  assign wrPrev    = wrPtr - 1'b1;
  assign wrIdx     = wrPtr[PW-1:0];
  assign rdIdx     = rdPtr[PW-1:0];
  assign newestIdx = wrPrev[PW-1:0];
  assign bufEmpty  = (wrPtr == rdPtr);
  assign headEntry = slots[rdIdx];

  always_comb begin
    newEntry           = '0;
    newEntry.data      = maskChar(inData, charSize);
    newEntry.frameErr  = inFrameErr;
    newEntry.overrun   = 1'b0;
    newEntry.parityErr = inParityErr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slots <= '0;
    end else begin
      for (int s = 0; s < DEPTH; s++) begin
        if (strb.push && !strb.flush && wrIdx == PW'(s)) begin
          slots[s] <= newEntry;
        end else if (strb.markOvr && !strb.flush && newestIdx == PW'(s)) begin
          slots[s].overrun <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      lastData <= '0;
    end else if (strb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= wrPtr + 1'b1;
      if (strb.pop) begin
        rdPtr    <= rdPtr + 1'b1;
        lastData <= headEntry.data[7:0];
      end
    end
  end

  generate
    if (DEPTH > 0) begin : g_ninth
      assign ninthBit = !bufEmpty && (charSize == SIZE_NINE) && headEntry.data[8];
    end
  endgenerate

  always_comb begin
    rdValue = '0;
    case (rdAddr)
      ADDR_STAT: begin
        rdValue[STAT_READY] = !bufEmpty;
        if (!bufEmpty) begin
          rdValue[STAT_FRAME]  = headEntry.frameErr;
          rdValue[STAT_OVRUN]  = headEntry.overrun;
          rdValue[STAT_PARITY] = headEntry.parityErr;
        end
      end
      ADDR_HIGH: rdValue[0] = ninthBit;
      ADDR_DATA: rdValue = bufEmpty ? lastData : headEntry.data[7:0];
      default:   rdValue = '0;
    endcase
  end

endmodule

// File: rtl/rx_hold_fifo.sv
module rx_hold_fifo
  import rx_hold_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxEnable,
  input  logic [2:0] charSize,
  input  logic       inValid,
  input  logic [8:0] inData,
  input  logic       inFrameErr,
  input  logic       inParityErr,
  input  logic       rdEn,
  input  logic [1:0] rdAddr,
  output logic [7:0] rdValue
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  fifoStrb_t        strb;
  logic [CNT_W-1:0] fillCount;

  rx_hold_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rxEnable  (rxEnable),
    .inValid   (inValid),
    .rdEn      (rdEn),
    .rdAddr    (rdAddr),
    .strb      (strb),
    .fillCount (fillCount)
  );

  rx_hold_dpath #(.DEPTH(DEPTH)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .charSize    (charSize),
    .inData      (inData),
    .inFrameErr  (inFrameErr),
    .inParityErr (inParityErr),
    .rdAddr      (rdAddr),
    .rdValue     (rdValue)
  );

endmodule

// File: rtl/rx_hold_chk.sv
module rx_hold_chk
  import rx_hold_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             rxEnable,
  input logic             inValid,
  input logic             rdEn,
  input logic [1:0]       rdAddr,
  input logic [7:0]       rdValue,
  input logic [CNT_W-1:0] fillCount,
  input fifoStrb_t        strb
);

  p_flush_r11: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (fillCount == '0));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_W'(DEPTH));

  p_ready_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == ADDR_STAT) |-> (rdValue[STAT_READY] == (fillCount != '0)));

  p_status_no_pop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && rdEn && rdAddr != ADDR_DATA && !inValid) |=> (fillCount == $past(fillCount)));

  p_empty_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && fillCount == '0 && !inValid) |=> (fillCount == '0));

  p_push_pop_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && strb.pop && !strb.flush) |=> (fillCount == $past(fillCount)));

endmodule

bind rx_hold_fifo rx_hold_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rxEnable  (rxEnable),
  .inValid   (inValid),
  .rdEn      (rdEn),
  .rdAddr    (rdAddr),
  .rdValue   (rdValue),
  .fillCount (fillCount),
  .strb      (strb)
);

// File: tb/rx_hold_fifo_bench.sv
`timescale 1ns/1ps
module rx_hold_fifo_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxEnable = 1'b0;
  logic [2:0] charSize = 3'd3;
  logic       inValid = 1'b0;
  logic [8:0] inData = '0;
  logic       inFrameErr = 1'b0;
  logic       inParityErr = 1'b0;
  logic       rdEn = 1'b0;
  logic [1:0] rdAddr = 2'd0;
  logic [7:0] rdValue;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  typedef struct {
    int data;
    bit fe;
    bit ovr;
    bit pe;
  } mEntry_t;

  mEntry_t mq[$];
  int      mLast = 0;
  int      mSize = 3;
  string   curTag = "R1";

  always #4 clk = ~clk;

  rx_hold_fifo u_rx_hold_fifo (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .charSize(charSize),
    .inValid(inValid), .inData(inData), .inFrameErr(inFrameErr),
    .inParityErr(inParityErr), .rdEn(rdEn), .rdAddr(rdAddr), .rdValue(rdValue)
  );

  function automatic int widthOf(int code);
    if (code <= 3) return code + 5;
    if (code == 7) return 9;
    return 8;
  endfunction

  function automatic int modelRead(int a);
    int v;
    v = 0;
    if (a == 0 && mq.size() > 0)
      v = 128 + (mq[0].fe ? 4 : 0) + (mq[0].ovr ? 2 : 0) + (mq[0].pe ? 1 : 0);
    else if (a == 1 && mq.size() > 0 && mSize == 7)
      v = (mq[0].data >> 8) & 1;
    else if (a == 2)
      v = (mq.size() > 0) ? (mq[0].data & 255) : mLast;
    return v;
  endfunction

  task automatic probeAll();
    for (int a = 0; a < 4; a++) begin
      int exp;
      rdAddr = 2'(a);
      #0.5;
      exp = modelRead(a);
      checks++;
      if (int'(rdValue) != exp) begin
        failures++;
        $display("FAIL %s addr=%0d actual=0x%02h expected=0x%02h", curTag, a, rdValue, exp);
      end
    end
  endtask

  task automatic modelStep(bit en, bit v, int d, bit fe, bit pe, bit re, int ra, int cs);
    bit popNow;
    bit full;
    mEntry_t e;
    if (!en) begin
      mq.delete();
      return;
    end
    full = (mq.size() == 2);
    popNow = re && ra == 2 && mq.size() > 0;
    if (popNow) begin
      mLast = mq[0].data & 255;
      void'(mq.pop_front());
    end
    if (v) begin
      if (full && !popNow) begin
        mq[mq.size()-1].ovr = 1'b1;
      end else begin
        e.data = d & ((1 << widthOf(cs)) - 1);
        e.fe = fe; e.pe = pe; e.ovr = 1'b0;
        mq.push_back(e);
      end
    end
  endtask

  // One clock: check the state left by the previous step, then apply stimulus.
  task automatic cyc(string tag, bit en, int cs, bit v, int d, bit fe, bit pe, bit re, int ra);
    probeAll();
    curTag = tag;
    rxEnable = en; charSize = 3'(cs); mSize = cs;
    inValid = v; inData = 9'(d); inFrameErr = fe; inParityErr = pe;
    rdEn = re; rdAddr = 2'(ra);
    @(posedge clk);
    modelStep(en, v, d, fe, pe, re, ra, cs);
    #1;
    inValid = 1'b0; rdEn = 1'b0;
  endtask

  task automatic push(string tag, int cs, int d, bit fe, bit pe);
    cyc(tag, 1'b1, cs, 1'b1, d, fe, pe, 1'b0, 0);
  endtask

  task automatic rd(string tag, int cs, int ra);
    cyc(tag, 1'b1, cs, 1'b0, 0, 1'b0, 1'b0, 1'b1, ra);
  endtask

  task automatic idle(string tag, int cs);
    cyc(tag, 1'b1, cs, 1'b0, 0, 1'b0, 1'b0, 1'b0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    curTag = "R1";
    probeAll();
    rstN = 1'b1;
    @(posedge clk);
    #1;
    idle("R1", 3);

    // R2 R3: single character in, read out, ready drops
    push("R2", 3, 'h0A5, 0, 0);
    idle("R2", 3);
    rd("R3", 3, 2);
    idle("R2", 3);

    // R3: two characters stacked, drained in order
    push("R3", 3, 'h011, 0, 0);
    push("R3", 3, 'h022, 0, 0);
    rd("R3", 3, 2);
    rd("R3", 3, 2);
    idle("R3", 3);

    // R9: empty data reads keep last value
    rd("R9", 3, 2);
    rd("R9", 3, 2);
    idle("R9", 3);

    // R4: masking across sizes
    for (int c = 0; c < 8; c++) begin
      push("R4", c, 'h1FF, 0, 0);
      rd("R4", c, 2);
    end
    push("R4", 1, 'h0C3, 0, 0);
    rd("R4", 1, 2);

    // R5: ninth bit
    push("R5", 7, 'h155, 0, 0);
    rd("R5", 7, 1);
    idle("R5", 7);
    rd("R5", 7, 2);
    push("R5", 3, 'h1AA, 0, 0);
    idle("R5", 3);
    rd("R5", 3, 2);

    // R6: per-entry flags
    push("R6", 3, 'h031, 1, 0);
    push("R6", 3, 'h032, 0, 1);
    idle("R6", 3);
    rd("R6", 3, 2);
    idle("R6", 3);
    rd("R6", 3, 2);
    idle("R6", 3);

    // R8: status/high reads do not remove
    push("R8", 7, 'h1E7, 1, 1);
    rd("R8", 7, 0);
    rd("R8", 7, 1);
    rd("R8", 7, 0);
    rd("R8", 7, 3);
    rd("R8", 7, 2);

    // R7: overrun on a full store
    push("R7", 3, 'h041, 0, 0);
    push("R7", 3, 'h042, 0, 0);
    push("R7", 3, 'h043, 1, 1);
    idle("R7", 3);
    rd("R7", 3, 2);
    idle("R7", 3);
    rd("R7", 3, 2);
    idle("R7", 3);

    // R10: push and pop together, empty-with-one and full
    push("R10", 3, 'h051, 0, 0);
    cyc("R10", 1'b1, 3, 1'b1, 'h052, 0, 1, 1'b1, 2);
    push("R10", 3, 'h053, 1, 0);
    cyc("R10", 1'b1, 3, 1'b1, 'h054, 0, 0, 1'b1, 2);
    idle("R10", 3);
    rd("R10", 3, 2);
    rd("R10", 3, 2);
    idle("R10", 3);

    // R11: flush and ignored strobes while disabled
    push("R11", 3, 'h061, 0, 0);
    push("R11", 3, 'h062, 0, 0);
    cyc("R11", 1'b0, 3, 1'b0, 0, 0, 0, 1'b0, 0);
    cyc("R11", 1'b0, 3, 1'b1, 'h063, 1, 1, 1'b0, 0);
    cyc("R11", 1'b0, 3, 1'b0, 0, 0, 0, 1'b1, 2);
    idle("R11", 3);
    push("R11", 3, 'h064, 0, 0);
    idle("R11", 3);
    rd("R11", 3, 2);
    idle("R11", 3);
    probeAll();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !done) begin
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<=20000 cycles", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

endmodule